// File: doc/BRIEF.md
# Zero-Overhead Nested Loop Sequencer

This block sits beside a program sequencer and runs counted loops without branch instructions in the instruction stream. When a repeat command is decoded, the block records the loop's first address, its last address and its iteration count. From then on it compares every fetch address with the stored last address. While iterations remain, it overrides the next fetch address with the loop's first address. A single-instruction repeat fetches the one instruction after the command N times. A block repeat runs the n instructions after the command N times.

Loops nest. When a repeat command arrives while a loop is already running, the running loop's context (first address, last address, remaining count) is pushed onto a small on-chip stack. When the inner loop finishes, the outer context is restored from the stack, so nesting costs no extra instructions.

A count of zero skips the body in the same cycle as the command. A stall input freezes all loop state and suppresses the override.

Top module: `hwloop_ctrl`

## Requirements
- R1: After a synchronous reset, `loop_active_o`, `overflow_o` and `redirect_o` are all 0, and the context stack is empty.
- R2: A command with `cmd_block_i`=0 (single repeat) at address P with count N≥1 causes the instruction at P+1 to be fetched exactly N times; `cmd_len_i` is ignored.
- R3: A command with `cmd_block_i`=1 (block repeat) at address P with count N≥1 and length n≥1 causes every address P+1 to P+n to be fetched exactly N times. Fetch then continues at P+n+1.
- R4: On the final iteration (remaining count 1) at the last address there is no override. When the stack is empty, `loop_active_o` is 0 from the next cycle on.
- R5: A command with count 0 drives `redirect_o`=1 with `redirect_pc_o` = last address + 1 in the same cycle. The body is never fetched, and any loop already running is unaffected.
- R6: A command issued while a loop is active saves the running loop on the stack. When the inner loop exits, the outer loop resumes with its remaining count and addresses.
- R7: The stack holds 4 contexts. A push when it is full is dropped, and `overflow_o` goes to 1 and stays there until reset. Four nested pushes leave `overflow_o` at 0.
- R8: While `stall_i`=1, `redirect_o` is 0 and no loop register, stack entry or command changes state.
- R9: The override fires only when a loop is active and the fetch address equals the stored last address. It targets the stored first address and reduces the remaining count by one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| stall_i | input | 1 | Pipeline stall; freezes all state |
| pc_i | input | PC_W | Current fetch address |
| cmd_valid_i | input | 1 | A repeat command is decoded at `pc_i` |
| cmd_block_i | input | 1 | 0 = single-instruction repeat, 1 = block repeat |
| cmd_count_i | input | CNT_W | Iteration count |
| cmd_len_i | input | PC_W | Block length in instructions (block repeat only) |
| redirect_o | output | 1 | Override the next fetch address |
| redirect_pc_o | output | PC_W | Next fetch address when `redirect_o` is 1 |
| loop_active_o | output | 1 | A loop is currently running |
| overflow_o | output | 1 | Sticky: a push hit a full stack |

## Verification
The bench emulates a fetch unit around the block and counts how many times each address is fetched. It sweeps both repeat kinds over counts 0 to 5 and block lengths 1 to 4. This separates an off-by-one in the count from an off-by-one in the end address, and shows whether a zero count wrongly runs the body once. Two nested programs check that an outer loop resumes correctly after its inner loop, and that a zero-count skip inside an active loop leaves the outer loop intact. Five-deep and six-deep nests land exactly on the stack-depth boundary. A periodic stall pattern runs through every program, so a stall that leaks state changes the fetch counts.

// File: rtl/hwloop_pkg.sv
package hwloop_pkg;

    typedef enum logic {
        REP_SINGLE = 1'b0,
        REP_BLOCK  = 1'b1
    } rep_kind_e;

endpackage

// File: rtl/hwloop_cmd_decode.sv
module hwloop_cmd_decode
    import hwloop_pkg::*;
#(
    parameter int PC_W = 16
) (
    input  logic [PC_W-1:0] pc_i,
    input  rep_kind_e       kind_i,
    input  logic [PC_W-1:0] len_i,
    output logic [PC_W-1:0] first_o,
    output logic [PC_W-1:0] last_o
);
    localparam logic [PC_W-1:0] PC_ONE = 1;

    // Body always begins right after the command; its end depends on the kind.
    always_comb begin
        first_o = pc_i + PC_ONE;
        if (kind_i == REP_BLOCK) begin
            last_o = pc_i + len_i;
        end else begin
            last_o = pc_i + PC_ONE;
        end
    end

endmodule

// File: rtl/hwloop_ctx_stack.sv
module hwloop_ctx_stack #(
    parameter int W     = 48,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push_i,
    input  logic         pop_i,
    input  logic [W-1:0] din_i,
    output logic [W-1:0] top_o,
    output logic         full_o,
    output logic         empty_o
);
    localparam int LVL_W = $clog2(DEPTH + 1);
    localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam logic [LVL_W-1:0] LVL_ONE = 1;
    localparam logic [LVL_W-1:0] LVL_MAX = LVL_W'(DEPTH);

    logic [W-1:0]     mem_d [DEPTH];
    logic [W-1:0]     mem_q [DEPTH];
    logic [LVL_W-1:0] lvl_d, lvl_q;
    logic [LVL_W-1:0] lvl_m1;
    logic [IDX_W-1:0] top_idx, wr_idx;

    assign lvl_m1  = lvl_q - LVL_ONE;
    assign top_idx = lvl_m1[IDX_W-1:0];
    assign wr_idx  = lvl_q[IDX_W-1:0];
    assign full_o  = (lvl_q == LVL_MAX);
    assign empty_o = (lvl_q == '0);
    assign top_o   = empty_o ? '0 : mem_q[top_idx];

    always_comb begin
        mem_d = mem_q;
        lvl_d = lvl_q;
        if (push_i && !full_o) begin
            mem_d[wr_idx] = din_i;
            lvl_d         = lvl_q + LVL_ONE;
        end else if (pop_i && !empty_o) begin
            lvl_d = lvl_m1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q <= '0;
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else begin
            lvl_q <= lvl_d;
            mem_q <= mem_d;
        end
    end

    // R7: the level never exceeds the configured depth
    a_r7_level_bound: assert property (@(posedge clk) disable iff (rst)
        lvl_q <= LVL_MAX);

    // R7: a push into a full stack leaves the level untouched
    a_r7_full_push_dropped: assert property (@(posedge clk) disable iff (rst)
        (push_i && full_o && !pop_i) |=> $stable(lvl_q));

endmodule

// File: rtl/hwloop_ctrl.sv
module hwloop_ctrl
    import hwloop_pkg::*;
#(
    parameter int PC_W  = 16,
    parameter int CNT_W = 16,
    parameter int DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             stall_i,
    input  logic [PC_W-1:0]  pc_i,
    input  logic             cmd_valid_i,
    input  logic             cmd_block_i,
    input  logic [CNT_W-1:0] cmd_count_i,
    input  logic [PC_W-1:0]  cmd_len_i,
    output logic             redirect_o,
    output logic [PC_W-1:0]  redirect_pc_o,
    output logic             loop_active_o,
    output logic             overflow_o
);
    localparam int CTX_W = 2 * PC_W + CNT_W;
    localparam logic [PC_W-1:0]  PC_ONE  = 1;
    localparam logic [CNT_W-1:0] CNT_ONE = 1;

    typedef struct packed {
        logic             active;
        logic             ovf;
        logic [PC_W-1:0]  first;
        logic [PC_W-1:0]  last;
        logic [CNT_W-1:0] cnt;
    } loop_state_t;

    loop_state_t st_d, st_q;

    logic [PC_W-1:0]  dec_first, dec_last;
    logic             push, pop;
    logic             stk_full, stk_empty;
    logic [CTX_W-1:0] stk_top;
    logic             redir;
    logic [PC_W-1:0]  redir_pc;

    hwloop_cmd_decode #(.PC_W(PC_W)) decode_i (
        .pc_i    (pc_i),
        .kind_i  (rep_kind_e'(cmd_block_i)),
        .len_i   (cmd_len_i),
        .first_o (dec_first),
        .last_o  (dec_last)
    );

    hwloop_ctx_stack #(.W(CTX_W), .DEPTH(DEPTH)) stack_i (
        .clk     (clk),
        .rst     (rst),
        .push_i  (push),
        .pop_i   (pop),
        .din_i   ({st_q.first, st_q.last, st_q.cnt}),
        .top_o   (stk_top),
        .full_o  (stk_full),
        .empty_o (stk_empty)
    );

    always_comb begin
        st_d     = st_q;
        push     = 1'b0;
        pop      = 1'b0;
        redir    = 1'b0;
        redir_pc = '0;
        if (!stall_i) begin
            if (cmd_valid_i) begin
                if (cmd_count_i == '0) begin
                    // empty loop: jump straight past the body
                    redir    = 1'b1;
                    redir_pc = dec_last + PC_ONE;
                end else begin
                    if (st_q.active) begin
                        push = 1'b1;
                        if (stk_full) st_d.ovf = 1'b1;
                    end
                    st_d.active = 1'b1;
                    st_d.first  = dec_first;
                    st_d.last   = dec_last;
                    st_d.cnt    = cmd_count_i;
                end
            end else if (st_q.active && (pc_i == st_q.last)) begin
                if (st_q.cnt > CNT_ONE) begin
                    redir    = 1'b1;
                    redir_pc = st_q.first;
                    st_d.cnt = st_q.cnt - CNT_ONE;
                end else begin
                    pop = 1'b1;
                    if (stk_empty) begin
                        st_d.active = 1'b0;
                    end else begin
                        {st_d.first, st_d.last, st_d.cnt} = stk_top;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign redirect_o    = redir;
    assign redirect_pc_o = redir_pc;
    assign loop_active_o = st_q.active;
    assign overflow_o    = st_q.ovf;

    // R8: a stalled cycle changes no loop register
    a_r8_stall_freezes: assert property (@(posedge clk) disable iff (rst)
        stall_i |=> ($stable(st_q.cnt) && $stable(st_q.active) && $stable(st_q.last)));

    // R7: overflow is sticky
    a_r7_overflow_sticky: assert property (@(posedge clk) disable iff (rst)
        st_q.ovf |=> st_q.ovf);

    // R9: a loop-back consumes exactly one iteration
    a_r9_loopback_decrements: assert property (@(posedge clk) disable iff (rst)
        (redirect_o && !cmd_valid_i) |=> (st_q.cnt == $past(st_q.cnt) - CNT_ONE));

    // R4: last iteration with nothing saved ends loop mode
    a_r4_exit_clears: assert property (@(posedge clk) disable iff (rst)
        (!stall_i && !cmd_valid_i && st_q.active && pc_i == st_q.last
         && st_q.cnt == CNT_ONE && stk_empty) |=> !loop_active_o);

    // R5: an empty loop leaves the running loop state unchanged
    a_r5_zero_count_keeps: assert property (@(posedge clk) disable iff (rst)
        (!stall_i && cmd_valid_i && cmd_count_i == '0)
        |=> ($stable(st_q.active) && $stable(st_q.cnt)));

endmodule

// File: tb/hwloop_ctrl_tb_top.sv
`timescale 1ns/1ps
module hwloop_ctrl_tb_top;
    localparam int PC_W  = 16;
    localparam int CNT_W = 16;
    localparam int HALT  = 40;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             stall_i = 1'b0;
    logic [PC_W-1:0]  pc_i = '0;
    logic             cmd_valid_i = 1'b0;
    logic             cmd_block_i = 1'b0;
    logic [CNT_W-1:0] cmd_count_i = '0;
    logic [PC_W-1:0]  cmd_len_i = '0;
    logic             redirect_o;
    logic [PC_W-1:0]  redirect_pc_o;
    logic             loop_active_o;
    logic             overflow_o;

    int n_chk  = 0;
    int n_fail = 0;

    bit p_cmd   [64];
    bit p_block [64];
    int p_cnt   [64];
    int p_len   [64];
    int hits    [64];

    always #5 clk = ~clk;

    hwloop_ctrl #(.PC_W(PC_W), .CNT_W(CNT_W), .DEPTH(4)) dut_i (
        .clk           (clk),
        .rst           (rst),
        .stall_i       (stall_i),
        .pc_i          (pc_i),
        .cmd_valid_i   (cmd_valid_i),
        .cmd_block_i   (cmd_block_i),
        .cmd_count_i   (cmd_count_i),
        .cmd_len_i     (cmd_len_i),
        .redirect_o    (redirect_o),
        .redirect_pc_o (redirect_pc_o),
        .loop_active_o (loop_active_o),
        .overflow_o    (overflow_o)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic clear_prog();
        for (int a = 0; a < 64; a++) begin
            p_cmd[a] = 0; p_block[a] = 0; p_cnt[a] = 0; p_len[a] = 0; hits[a] = 0;
        end
    endtask

    task automatic put(input int a, input bit blk, input int cnt, input int len);
        p_cmd[a] = 1; p_block[a] = blk; p_cnt[a] = cnt; p_len[a] = len;
    endtask

    // Emulated fetch unit: runs the program from address 8 until HALT.
    task automatic run_prog(input bit check_reset);
        int pc;
        int cyc;
        pc  = 8;
        cyc = 0;
        @(posedge clk); #1;
        rst = 1'b1; cmd_valid_i = 1'b0; stall_i = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst = 1'b0;
        if (check_reset) begin
            @(negedge clk);
            chk(loop_active_o == 1'b0, "R1 loop_active after reset", int'(loop_active_o), 0);
            chk(overflow_o == 1'b0, "R1 overflow after reset", int'(overflow_o), 0);
            chk(redirect_o == 1'b0, "R1 redirect after reset", int'(redirect_o), 0);
        end
        while (pc != HALT && cyc < 3000) begin
            @(posedge clk); #1;
            pc_i        = PC_W'(pc);
            cmd_valid_i = p_cmd[pc];
            cmd_block_i = p_block[pc];
            cmd_count_i = CNT_W'(p_cnt[pc]);
            cmd_len_i   = PC_W'(p_len[pc]);
            stall_i     = (cyc % 7 == 3);
            @(negedge clk);
            if (stall_i) begin
                chk(redirect_o == 1'b0, "R8 no redirect while stalled", int'(redirect_o), 0);
            end else begin
                hits[pc]++;
                pc = redirect_o ? int'(redirect_pc_o) : pc + 1;
                if (pc > 63) pc = HALT + 1;
            end
            cyc++;
        end
        chk(pc == HALT, "R3 program reached halt address", pc, HALT);
        @(posedge clk); #1;
        cmd_valid_i = 1'b0; stall_i = 1'b0; pc_i = PC_W'(HALT);
        @(negedge clk);
        chk(loop_active_o == 1'b0, "R4 loop mode cleared after exit", int'(loop_active_o), 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        bit first_run;
        first_run = 1;
        // Sweep: both kinds, counts 0..5, lengths 1..4
        for (int kind = 0; kind < 2; kind++) begin
            for (int cnt = 0; cnt <= 5; cnt++) begin
                for (int len = 1; len <= 4; len++) begin
                    int last;
                    clear_prog();
                    put(10, bit'(kind), cnt, len);
                    run_prog(first_run);
                    first_run = 0;
                    last = (kind == 1) ? 10 + len : 11;
                    chk(hits[10] == 1, "R5 command fetched once", hits[10], 1);
                    for (int a = 11; a <= last; a++) begin
                        if (kind == 1)
                            chk(hits[a] == cnt, "R3 block body fetch count", hits[a], cnt);
                        else
                            chk(hits[a] == cnt, "R2 single repeat fetch count", hits[a], cnt);
                    end
                    chk(hits[last + 1] == 1, "R9 fall-through fetched once", hits[last + 1], 1);
                    chk(overflow_o == 1'b0, "R7 no overflow in flat loop", int'(overflow_o), 0);
                end
            end
        end

        // Nested: outer 3 x (11..16), inner 4 x (12..13), zero-count skip at 14
        clear_prog();
        put(10, 1, 3, 6);
        put(11, 1, 4, 2);
        put(14, 1, 0, 1);
        run_prog(0);
        chk(hits[11] == 3, "R6 outer body start", hits[11], 3);
        chk(hits[12] == 12, "R6 inner body first", hits[12], 12);
        chk(hits[13] == 12, "R6 inner body last", hits[13], 12);
        chk(hits[14] == 3, "R6 outer resumes after inner", hits[14], 3);
        chk(hits[15] == 0, "R5 skipped body inside active loop", hits[15], 0);
        chk(hits[16] == 3, "R5 outer loop intact after skip", hits[16], 3);
        chk(hits[17] == 1, "R6 exit after outer", hits[17], 1);

        // Five levels: four pushes, exactly fills the stack
        clear_prog();
        put(10, 1, 2, 20);
        put(11, 1, 1, 18);
        put(12, 1, 1, 16);
        put(13, 1, 1, 14);
        put(14, 1, 1, 12);
        run_prog(0);
        chk(overflow_o == 1'b0, "R7 four pushes do not overflow", int'(overflow_o), 0);
        chk(hits[11] == 2, "R7 outermost loop restored", hits[11], 2);
        chk(hits[30] == 2, "R7 outermost end fetched", hits[30], 2);
        chk(hits[31] == 1, "R7 exit after outermost", hits[31], 1);

        // Six levels: fifth push dropped
        clear_prog();
        put(10, 1, 2, 20);
        put(11, 1, 1, 18);
        put(12, 1, 1, 16);
        put(13, 1, 1, 14);
        put(14, 1, 1, 12);
        put(15, 1, 1, 10);
        run_prog(0);
        chk(overflow_o == 1'b1, "R7 overflow flag set", int'(overflow_o), 1);
        chk(hits[11] == 2, "R7 outer loop survives overflow", hits[11], 2);
        chk(hits[31] == 1, "R7 exit after overflowed nest", hits[31], 1);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule